// File: doc/BRIEF.md
# Multicycle Load/Store/Branch Processor Core

This core runs a small 32-bit instruction subset: word load, word store, branch-if-equal, the register operations add, subtract, AND, OR and signed set-on-less-than, and a logical right shift by an immediate amount. Every instruction passes through a finite-state sequencer. The phases are instruction fetch, register read, execute, memory access and register write. An instruction uses only the phases it needs. A single 32-bit adder/logic unit does all arithmetic. It advances the program counter during fetch, forms the branch target during register read, and produces the result or the effective address during execute.

The core has one memory port, which is shared by instruction fetch and data access. The port carries a word address, separate read and write strobes, and a write-data bus. Read data must be valid in the same cycle as the address. The register file holds 32 words. Register 0 always reads as zero.

Decoding happens in two steps. The opcode sets the control lines and a 2-bit operation class. The operation class, together with the function field for register instructions, then selects the arithmetic operation.

Top module: `mc_core`

## Requirements
- R1: In the first cycle after synchronous active-low reset, the core reads memory word 0 (`mem_rd`=1, `mem_addr`=0, `mem_wr`=0). The program counter starts at byte address 0.
- R2: Instruction latency in clock cycles is fixed: load 5; store, register operations and shift 4; branch 3. The next instruction fetch follows directly.
- R3: `mem_rd` and `mem_wr` are never high in the same cycle. `mem_addr` is the byte address divided by 4.
- R4: Opcode (bits 31:26) 000000 selects a register operation. The function field (bits 5:0) selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed less-than (result 1 or 0). The sources are rs (bits 25:21) and rt (bits 20:16). The destination is rd (bits 15:11).
- R5: Function 000010 shifts rt logically right by the amount in bits 10:6 and writes the result to rd. Shift amounts 0 and 31 work.
- R6: Opcode 100011 loads the word at rs plus the sign-extended bits 15:0 into rt. Negative offsets work.
- R7: Opcode 101011 writes rt to the word at rs plus the sign-extended offset. `mem_wr` is high only in the memory phase of a store.
- R8: Opcode 000100 compares rs and rt by subtraction, whatever bits 5:0 hold. When they are equal, the PC becomes PC+4 plus the sign-extended offset shifted left by 2. Otherwise execution continues at PC+4.
- R9: Register 0 reads as zero, and writes to it have no effect.
- R10: At the end of fetch, the shared unit's PC+4 and the fetched word are latched on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 30 | Word address for fetch or data access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |

## Verification
The assertions assume three things about the environment: memory answers a read in the same cycle, every fetched word is a defined instruction, and all addresses are word-aligned. The program used as stimulus obeys all three. It uses only the listed opcodes and function codes, keeps every load and store offset a multiple of 4, and ends in a self-branch. Because of that self-branch, the core never fetches a word the test did not place in memory. Results are observed only through the store port. Each arithmetic, shift, load or branch outcome is therefore followed by a store whose data, address and cycle the scoreboard predicts.

// File: rtl/mc_pkg.sv
// Package mc_pkg: shared encodings for the multicycle core.
// Assumes a 32-bit instruction word with a 6-bit opcode in bits 31:26.
package mc_pkg;

    typedef enum logic [2:0] {
        S_FETCH  = 3'd0,
        S_DECODE = 3'd1,
        S_EXEC   = 3'd2,
        S_MEM    = 3'd3,
        S_WB     = 3'd4
    } state_t;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SRL = 3'b011,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_t;

    localparam logic [5:0] OP_REG   = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_SRL = 6'b000010;

    // Control lines produced from the opcode alone.
    typedef struct packed {
        logic       known;
        logic       dst_rd;
        logic       reg_write;
        logic       imm_src;
        logic       branch;
        logic       mem_read;
        logic       mem_write;
        logic       from_mem;
        logic [1:0] op_class;
    } ctl_t;

endpackage

// File: rtl/mc_alu.sv
// Module mc_alu: the single shared arithmetic/logic unit.
// Assumes the operation code is one of alu_t; unknown codes give add.
module mc_alu
    import mc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [SH_W-1:0]   shamt,
    input  alu_t              op,
    output logic [DATA_W-1:0] y,
    output logic              zero
);

    // Compute the selected operation.
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SRL: y = b >> shamt;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mc_alu_dec.sv
// Module mc_alu_dec: second decode level, class plus function field to operation.
// Assumes class 00 = address add, 01 = compare, 10 = register op.
module mc_alu_dec
    import mc_pkg::*;
(
    input  logic [1:0] op_class,
    input  logic [5:0] funct,
    output alu_t       op
);

    // Map the class and the function field to an ALU operation.
    always_comb begin
        op = ALU_ADD;
        case (op_class)
            2'b01: op = ALU_SUB;
            2'b10: begin
                case (funct)
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    FN_SRL:  op = ALU_SRL;
                    default: op = ALU_ADD;
                endcase
            end
            default: op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
// Module mc_regfile: two read ports, one write port, entry 0 fixed at zero.
// Assumes reads are combinational and the write lands on the rising edge.
module mc_regfile #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    localparam int NREG  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [IDX_W-1:0]  ra1,
    input  logic [IDX_W-1:0]  ra2,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2
);

    logic [DATA_W-1:0] regs [1:NREG-1];

    // Write any entry except 0.
    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    // Read with entry 0 forced to zero.
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mc_ctrl.sv
// Module mc_ctrl: phase sequencer and first decode level (opcode to control lines).
// Assumes the opcode input is the instruction register, stable after fetch.
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    output state_t     state,
    output ctl_t       ctl
);

    state_t nxt;

    // Decode the opcode into control lines and an operation class.
    always_comb begin
        ctl = '0;
        case (opcode)
            OP_REG:   begin ctl.known = 1'b1; ctl.dst_rd = 1'b1; ctl.reg_write = 1'b1; ctl.op_class = 2'b10; end
            OP_LOAD:  begin ctl.known = 1'b1; ctl.imm_src = 1'b1; ctl.from_mem = 1'b1;
                            ctl.reg_write = 1'b1; ctl.mem_read = 1'b1; end
            OP_STORE: begin ctl.known = 1'b1; ctl.imm_src = 1'b1; ctl.mem_write = 1'b1; end
            OP_BEQ:   begin ctl.known = 1'b1; ctl.branch = 1'b1; ctl.op_class = 2'b01; end
            default:  ctl = '0;
        endcase
    end

    // Choose the next phase from the current phase and the control lines.
    always_comb begin
        case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: nxt = ctl.known ? S_EXEC : S_FETCH;
            S_EXEC:   nxt = ctl.branch ? S_FETCH :
                            (ctl.mem_read || ctl.mem_write) ? S_MEM : S_WB;
            S_MEM:    nxt = ctl.mem_read ? S_WB : S_FETCH;
            default:  nxt = S_FETCH;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= nxt;
    end

    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH |=> state == S_DECODE);
    p_load_reaches_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MEM && ctl.mem_read) |=> state == S_WB);
    p_branch_three_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && ctl.branch) |=> state == S_FETCH);

endmodule

// File: rtl/mc_core.sv
// Module mc_core: multicycle core with one shared ALU and one memory port.
// Assumes memory read data is valid in the same cycle as mem_addr/mem_rd.
module mc_core
    import mc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 30,
    parameter int IDX_W  = 5,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [DATA_W-1:0] pc, ir, a_q, b_q, res_q, mdr;
    logic [DATA_W-1:0] src_a, src_b, alu_y, rd1, rd2, imm, wd;
    logic              alu_zero;
    alu_t              dec_op, alu_op;
    state_t            state;
    ctl_t              ctl;

    mc_ctrl u_ctrl (.clk(clk), .rst_n(rst_n), .opcode(ir[31:26]), .state(state), .ctl(ctl));

    mc_alu_dec u_dec (.op_class(ctl.op_class), .funct(ir[5:0]), .op(dec_op));

    mc_alu #(.DATA_W(DATA_W)) u_alu (
        .a(src_a), .b(src_b), .shamt(ir[6+SH_W-1:6]), .op(alu_op), .y(alu_y), .zero(alu_zero));

    assign wd = ctl.from_mem ? mdr : res_q;

    mc_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
        .clk(clk), .we(state == S_WB && ctl.reg_write),
        .wa(ctl.dst_rd ? ir[15:11] : ir[20:16]), .wd(wd),
        .ra1(ir[25:21]), .ra2(ir[20:16]), .rd1(rd1), .rd2(rd2));

    assign imm = {{(DATA_W-16){ir[15]}}, ir[15:0]};

    // Route the shared ALU: PC+4 in fetch, branch target in decode, operands in execute.
    always_comb begin
        src_a  = pc;
        src_b  = DATA_W'(4);
        alu_op = ALU_ADD;
        case (state)
            S_DECODE: src_b = imm << 2;
            S_EXEC: begin
                src_a  = a_q;
                src_b  = ctl.imm_src ? imm : b_q;
                alu_op = dec_op;
            end
            default: ;
        endcase
    end

    assign mem_addr  = (state == S_MEM) ? res_q[ADDR_W+1:2] : pc[ADDR_W+1:2];
    assign mem_rd    = (state == S_FETCH) || (state == S_MEM && ctl.mem_read);
    assign mem_wr    = (state == S_MEM) && ctl.mem_write;
    assign mem_wdata = b_q;

    logic unused_low;
    assign unused_low = ^{pc[1:0], res_q[1:0]};

    // Datapath registers, each loaded in its own phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            case (state)
                S_FETCH: begin
                    ir <= mem_rdata;
                    pc <= alu_y;
                end
                S_DECODE: begin
                    a_q   <= rd1;
                    b_q   <= rd2;
                    res_q <= alu_y;
                end
                S_EXEC: begin
                    if (ctl.branch) begin
                        if (alu_zero) pc <= res_q;
                    end else begin
                        res_q <= alu_y;
                    end
                end
                S_MEM: if (ctl.mem_read) mdr <= mem_rdata;
                default: ;
            endcase
        end
    end

    p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH |=> pc == $past(pc) + DATA_W'(4));
    p_ir_same_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH |=> ir == $past(mem_rdata));
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    p_store_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (state == S_MEM && ir[31:26] == OP_STORE));
    p_fetch_reads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH |-> (mem_rd && mem_addr == pc[ADDR_W+1:2]));

endmodule

// File: tb/test_mc_core.sv
// Bench test_mc_core: scoreboard of predicted stores (cycle, address, data).
module test_mc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    mc_core i_mc_core (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
                       .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    logic [31:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    typedef struct {
        int          cyc;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } item_t;
    item_t sb[$];

    int cyc, tcyc, pw, checks, errors;
    bit done;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic emit(logic [31:0] instr, int len);
        mem[pw] = instr;
        pw++;
        tcyc += len;
    endtask
    task automatic emit_store(int rt, int off, logic [31:0] exp, string tag);
        item_t it;
        it.cyc = tcyc + 3; it.addr = 32'(off); it.data = exp; it.tag = tag;
        sb.push_back(it);
        emit(enc_i(6'b101011, 0, rt, off), 4);
    endtask

    // Monitor: pop the oldest prediction on every store and compare.
    always @(negedge clk) begin
        if (rst_n && mem_wr && !done) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected store: addr=%h data=%h expected no store", mem_addr, mem_wdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (cyc != it.cyc || mem_addr != it.addr[31:2] || mem_wdata != it.data || mem_rd) begin
                    errors++;
                    $display("FAIL %s (R2/R3/R10 timing): cyc=%0d addr=%h data=%h rd=%b expected cyc=%0d addr=%h data=%h rd=0",
                             it.tag, cyc, mem_addr, mem_wdata, mem_rd, it.cyc, it.addr[31:2], it.data);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h1000FFFF;
        mem[128] = 32'd7;
        mem[129] = 32'hFFFF_FFFD;
        mem[130] = 32'hF0F0_00A5;
        mem[131] = 32'h0000_0210;
        pw = 0; tcyc = 0; checks = 0; errors = 0; done = 0;

        emit(enc_i(6'b100011, 0, 1, 'h200), 5);
        emit(enc_i(6'b100011, 0, 2, 'h204), 5);
        emit(enc_i(6'b100011, 0, 3, 'h208), 5);
        emit(enc_i(6'b100011, 0, 6, 'h20C), 5);
        emit(enc_r(1, 2, 7, 0, 6'b100000), 4); emit_store(7, 'h300, 32'd4, "R4 add");
        emit(enc_r(1, 2, 7, 0, 6'b100010), 4); emit_store(7, 'h304, 32'd10, "R4 sub");
        emit(enc_r(1, 3, 7, 0, 6'b100100), 4); emit_store(7, 'h308, 32'd5, "R4 and");
        emit(enc_r(1, 3, 7, 0, 6'b100101), 4); emit_store(7, 'h30C, 32'hF0F0_00A7, "R4 or");
        emit(enc_r(2, 1, 7, 0, 6'b101010), 4); emit_store(7, 'h310, 32'd1, "R4 slt true");
        emit(enc_r(1, 2, 7, 0, 6'b101010), 4); emit_store(7, 'h314, 32'd0, "R4 slt false");
        emit(enc_r(0, 3, 7, 4, 6'b000010), 4); emit_store(7, 'h318, 32'h0F0F_000A, "R5 srl 4");
        emit(enc_r(0, 3, 7, 0, 6'b000010), 4); emit_store(7, 'h31C, 32'hF0F0_00A5, "R5 srl 0");
        emit(enc_r(0, 2, 7, 31, 6'b000010), 4); emit_store(7, 'h320, 32'd1, "R5 srl 31");
        emit(enc_i(6'b100011, 6, 5, -4), 5); emit_store(5, 'h324, 32'h0000_0210, "R6 negative offset");
        emit(enc_r(1, 1, 0, 0, 6'b100000), 4); emit_store(0, 'h328, 32'd0, "R9 reg0");
        // R8: offset 36 has low bits 100100 (the AND code); equal values must still branch.
        emit(enc_i(6'b000100, 1, 1, 36), 3);
        mem[27] = enc_i(6'b101011, 0, 1, 'h3FC);
        pw = 63;
        emit(enc_i(6'b000100, 1, 2, 1), 3);
        emit_store(1, 'h32C, 32'd7, "R8 not taken");
        emit(32'h1000FFFF, 3);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        checks++;
        if (!(mem_rd && !mem_wr && mem_addr == 30'd0)) begin
            errors++;
            $display("FAIL R1 reset fetch: rd=%b wr=%b addr=%h expected rd=1 wr=0 addr=0", mem_rd, mem_wr, mem_addr);
        end

        for (int i = 0; i < 5000 && cyc < tcyc + 20; i++) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            checks++;
            if (sb.size() != 0) begin
                errors++;
                $display("FAIL R2/R7/R8 missing stores: left=%0d expected 0", sb.size());
            end
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: cyc=%0d expected end by %0d", cyc, tcyc + 20);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule